// File: doc/BRIEF.md
# Measurement Mode and Rate Sequencer

This block decides when a three-axis field sensor takes a sample. It holds the control byte that selects the operating mode, the output rate and the oversampling. From a prescaled 1280 Hz base tick it produces one-cycle acquire pulses, either at a steady rate, once for a triggered measurement, or once at a shortened period when a trigger lands during continuous operation. It also reports a two-bit system-mode code. While the sequencer is running, it refuses every control field except the two run bits.

A second configuration byte enables an automatic sensor-reset pulse before each acquire, selects raw or user-corrected output, and starts a manual sensor-reset cycle. Each raw sample word coming back from the converter has an even-valued user offset added to it per axis, unless raw mode is selected. The result is registered and passed on to the downstream data-ready tracker.

Top module: `msr_seq`

## Requirements
- R1: After reset, `ctrl_rdata`, `cfg_rdata`, `sysmode`, `acq`, `srst` and `trig_busy` are all 0.
- R2: Control byte layout, bit 7 down to 0: rate[2:0], osr[1:0], fast-read, trigger (bit 1), active (bit 0). With active=1 and trigger=0, `acq` first pulses P+1 cycles after the write edge and then every P cycles. P = DIV*16*2^(rate+osr), where DIV = CLK_HZ/1280.
- R3: While active=0 and trigger=0 (standby), `acq` never pulses.
- R4: Writing trigger=1 and active=0 from standby raises `trig_busy` and starts one measurement at the programmed period P. `acq` pulses once, P+1 cycles after the write edge. In that same cycle the trigger bit and `trig_busy` clear, and the block returns to standby.
- R5: Setting trigger=1 while continuous makes the next `acq` arrive DIV*16*2^osr cycles after the previous one. The trigger bit clears with that pulse, and the following interval is P again.
- R6: While active or trigger is set, a control write changes only bits 1:0. The other six bits keep their value.
- R7: `sysmode` is 00 in standby. When running it is 01 with raw mode and 10 with corrected mode.
- R8: With raw mode off, each 16-bit axis word of `cor_xyz` equals the sample word plus the offset word with its bit 0 cleared, modulo 2^16. The axes are x in [15:0], y in [31:16] and z in [47:32]. The result and `cor_valid` appear one cycle after `smp_valid`.
- R9: With raw mode on (configuration bit 5), `cor_xyz` equals the sample unchanged.
- R10: With auto-reset enabled (configuration bit 7), `srst` is high in the cycle just before every `acq`. Bit 7 of `cfg_rdata` always reads 0.
- R11: Writing configuration bit 4 pulses `srst` in the cycle after the write edge. Bit 4 of `cfg_rdata` then reads 1 for RST_CYC cycles and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte (bit 7 auto-reset, bit 5 raw, bit 4 manual reset) |
| ofs_xyz | input | 48 | User offset words, z/y/x |
| smp_valid | input | 1 | Raw sample strobe |
| smp_xyz | input | 48 | Raw sample words, z/y/x |
| acq | output | 1 | One-cycle acquire request |
| srst | output | 1 | One-cycle sensor-reset request |
| trig_busy | output | 1 | Triggered measurement from standby in progress |
| sysmode | output | 2 | System mode code |
| ctrl_rdata | output | 8 | Control byte readback |
| cfg_rdata | output | 8 | Configuration readback |
| cor_valid | output | 1 | Corrected sample strobe |
| cor_xyz | output | 48 | Corrected sample words, z/y/x |

## Verification
The hardest situation to reach from the ports is a trigger arriving in the middle of continuous operation, because its effect depends on how far the period counter has advanced. The stimulus waits for an acquire pulse and writes the trigger on the very next cycle. This fixes the counter phase, so the shortened interval and the interval after it can be predicted exactly. Random rate and oversampling fields, and random sample and offset words, cover the remaining space.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int BASE_HZ        = 1280;
    localparam int TOP_RATE_TICKS = 16;
    localparam int PER_W          = 15;
    localparam int AXES           = 3;
    localparam int SMP_W          = 16;
    localparam int BUS_W          = AXES * SMP_W;

    localparam logic [7:0] CFG_AUTO_M = 8'h80;
    localparam logic [7:0] CFG_RAW_M  = 8'h20;
    localparam logic [7:0] CFG_MRST_M = 8'h10;

    typedef enum logic [1:0] {
        SYS_STBY = 2'b00,
        SYS_RAW  = 2'b01,
        SYS_COR  = 2'b10
    } sysmode_e;

    typedef struct packed {
        logic [2:0] rate;
        logic [1:0] osr;
        logic       fast_rd;
        logic       trig;
        logic       act;
    } ctrl_t;

    function automatic logic [PER_W-1:0] prog_ticks(input logic [2:0] rate, input logic [1:0] osr);
        logic [3:0] sh;
        sh = {1'b0, rate} + {2'b00, osr};
        return PER_W'(TOP_RATE_TICKS) << sh;
    endfunction

    function automatic logic [PER_W-1:0] fast_ticks(input logic [1:0] osr);
        return PER_W'(TOP_RATE_TICKS) << osr;
    endfunction

    function automatic logic [SMP_W-1:0] ofs_even(input logic [SMP_W-1:0] o);
        return o & ~SMP_W'(1);
    endfunction

    function automatic logic bit_set(input logic [7:0] b, input logic [7:0] m);
        return (b & m) != 8'h00;
    endfunction

endpackage

// File: rtl/msr_prescale.sv
module msr_prescale
    import msr_pkg::*;
#(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_cnt
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/msr_rate.sv
module msr_rate
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [PER_W-1:0] lim,
    output logic             fire_q
);
    logic [PER_W-1:0] per;
    logic             fire;

    assign fire = tick && (per >= lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            per    <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= fire;
            if (fire) begin
                per <= '0;
            end else if (tick) begin
                per <= per + 1'b1;
            end
        end
    end
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
    import msr_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wd,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wd,
    input  logic       trig_done,
    output ctrl_t      ctrl_q,
    output logic       auto_en,
    output logic       raw_en,
    output logic       mrst_busy,
    output logic       mrst_pls
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic [RC_W-1:0] rc_cnt;
    logic            standby;
    logic            mrst_req;

    assign standby  = !(ctrl_q.act || ctrl_q.trig);
    assign mrst_req = cfg_we && bit_set(cfg_wd, CFG_MRST_M) && (rc_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            auto_en  <= 1'b0;
            raw_en   <= 1'b0;
            rc_cnt   <= '0;
            mrst_pls <= 1'b0;
        end else begin
            if (ctrl_we) begin
                if (standby) begin
                    ctrl_q <= ctrl_t'(ctrl_wd);
                end else begin
                    ctrl_q.act  <= ctrl_wd[0];
                    ctrl_q.trig <= ctrl_wd[1];
                end
            end else if (trig_done) begin
                ctrl_q.trig <= 1'b0;
            end

            if (cfg_we) begin
                auto_en <= bit_set(cfg_wd, CFG_AUTO_M);
                raw_en  <= bit_set(cfg_wd, CFG_RAW_M);
            end

            mrst_pls <= mrst_req;
            if (mrst_req) begin
                rc_cnt <= RC_W'(RST_CYC);
            end else if (rc_cnt != '0) begin
                rc_cnt <= rc_cnt - 1'b1;
            end
        end
    end

    assign mrst_busy = (rc_cnt != '0);
endmodule

// File: rtl/msr_ofs_add.sv
module msr_ofs_add
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_en,
    input  logic             smp_valid,
    input  logic [BUS_W-1:0] smp,
    input  logic [BUS_W-1:0] ofs,
    output logic             cor_valid,
    output logic [BUS_W-1:0] cor
);
    generate
        for (genvar a = 0; a < AXES; a++) begin : g_axis
            logic [SMP_W-1:0] addend;
            logic [SMP_W-1:0] sum_q;

            assign addend = raw_en ? '0 : ofs_even(ofs[a*SMP_W +: SMP_W]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    sum_q <= '0;
                end else if (smp_valid) begin
                    sum_q <= smp[a*SMP_W +: SMP_W] + addend;
                end
            end

            assign cor[a*SMP_W +: SMP_W] = sum_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cor_valid <= 1'b0;
        end else begin
            cor_valid <= smp_valid;
        end
    end
endmodule

// File: rtl/msr_seq.sv
module msr_seq
    import msr_pkg::*;
#(
    parameter int CLK_HZ  = 1_280_000,
    parameter int RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic [BUS_W-1:0] ofs_xyz,
    input  logic             smp_valid,
    input  logic [BUS_W-1:0] smp_xyz,
    output logic             acq,
    output logic             srst,
    output logic             trig_busy,
    output logic [1:0]       sysmode,
    output logic [7:0]       ctrl_rdata,
    output logic [7:0]       cfg_rdata,
    output logic             cor_valid,
    output logic [BUS_W-1:0] cor_xyz
);
    localparam int DIV = (CLK_HZ / BASE_HZ) < 1 ? 1 : (CLK_HZ / BASE_HZ);

    ctrl_t            ctrl;
    logic             auto_en;
    logic             raw_en;
    logic             mrst_busy;
    logic             mrst_pls;
    logic             run;
    logic             tick;
    logic             fire_q;
    logic [PER_W-1:0] lim;
    sysmode_e         mode;

    msr_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .ctrl_wd   (ctrl_wdata),
        .cfg_we    (cfg_we),
        .cfg_wd    (cfg_wdata),
        .trig_done (fire_q),
        .ctrl_q    (ctrl),
        .auto_en   (auto_en),
        .raw_en    (raw_en),
        .mrst_busy (mrst_busy),
        .mrst_pls  (mrst_pls)
    );

    assign run = ctrl.act || ctrl.trig;
    // a trigger during continuous operation shortens to the fastest period for this oversampling
    assign lim = (ctrl.act && ctrl.trig) ? fast_ticks(ctrl.osr) : prog_ticks(ctrl.rate, ctrl.osr);

    msr_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    msr_rate u_rate (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (tick),
        .lim    (lim),
        .fire_q (fire_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acq <= 1'b0;
        end else begin
            acq <= fire_q;
        end
    end

    assign srst = mrst_pls || (auto_en && fire_q);

    msr_ofs_add u_ofs (
        .clk       (clk),
        .rst       (rst),
        .raw_en    (raw_en),
        .smp_valid (smp_valid),
        .smp       (smp_xyz),
        .ofs       (ofs_xyz),
        .cor_valid (cor_valid),
        .cor       (cor_xyz)
    );

    always_comb begin
        if (!run)        mode = SYS_STBY;
        else if (raw_en) mode = SYS_RAW;
        else             mode = SYS_COR;
    end

    assign sysmode    = mode;
    assign trig_busy  = ctrl.trig && !ctrl.act;
    assign ctrl_rdata = ctrl;
    assign cfg_rdata  = {2'b00, raw_en, mrst_busy, 4'b0000};
endmodule

// File: rtl/msr_seq_chk.sv
module msr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_we,
    input logic       acq,
    input logic       srst,
    input logic       trig_busy,
    input logic [1:0] sysmode,
    input logic [7:0] ctrl_rdata,
    input logic [7:0] cfg_rdata,
    input logic       smp_valid,
    input logic       cor_valid,
    input logic       auto_en
);
    // R2
    acq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        acq |=> !acq);

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rdata[1:0] == 2'b00 && $past(ctrl_rdata[1:0]) == 2'b00 && $past(ctrl_rdata[1:0], 2) == 2'b00) |-> !acq);

    // R4
    trig_end_acq_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(trig_busy) && !$past(ctrl_we)) |-> acq);

    // R6
    locked_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_rdata[1:0] != 2'b00) |=> ctrl_rdata[7:2] == $past(ctrl_rdata[7:2]));

    // R7
    mode_code_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_rdata[1:0] == 2'b00) == (sysmode == 2'b00)) && sysmode != 2'b11);

    // R8
    cor_latency_chk: assert property (@(posedge clk) disable iff (rst)
        cor_valid == $past(smp_valid));

    // R10
    auto_reset_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (acq && $past(auto_en)) |-> $past(srst));

    // R11
    manual_reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_rdata[4]) |-> srst);
endmodule

bind msr_seq msr_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .acq        (acq),
    .srst       (srst),
    .trig_busy  (trig_busy),
    .sysmode    (sysmode),
    .ctrl_rdata (ctrl_rdata),
    .cfg_rdata  (cfg_rdata),
    .smp_valid  (smp_valid),
    .cor_valid  (cor_valid),
    .auto_en    (auto_en)
);

// File: tb/msr_seq_tb.sv
module msr_seq_tb;
    localparam int CLK_HZ  = 2560;
    localparam int DIV     = 2;
    localparam int RST_CYC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [47:0] ofs_xyz = '0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_xyz = '0;
    logic        acq, srst, trig_busy, cor_valid;
    logic [1:0]  sysmode;
    logic [7:0]  ctrl_rdata, cfg_rdata;
    logic [47:0] cor_xyz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msr_seq #(.CLK_HZ(CLK_HZ), .RST_CYC(RST_CYC)) u_dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ofs_xyz(ofs_xyz),
        .smp_valid(smp_valid), .smp_xyz(smp_xyz), .acq(acq), .srst(srst),
        .trig_busy(trig_busy), .sysmode(sysmode), .ctrl_rdata(ctrl_rdata),
        .cfg_rdata(cfg_rdata), .cor_valid(cor_valid), .cor_xyz(cor_xyz)
    );

    function automatic int per_cyc(int dr, int os);
        return DIV * 16 * (1 << (dr + os));
    endfunction

    function automatic logic [47:0] ref_cor(logic [47:0] s, logic [47:0] o, bit raw);
        logic [47:0] r;
        for (int a = 0; a < 3; a++) begin
            logic [15:0] add;
            add = raw ? 16'h0000 : (o[a*16 +: 16] & 16'hFFFE);
            r[a*16 +: 16] = s[a*16 +: 16] + add;
        end
        return r;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_cfg(logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wait_acq(int maxc, output int n, output bit sr_before);
        bit prev;
        n = 0;
        sr_before = 1'b0;
        prev = srst;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (acq) begin
                sr_before = prev;
                break;
            end
            prev = srst;
        end
    endtask

    task automatic count_acq(int cyc, output int k);
        k = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (acq) k++;
        end
    endtask

    task automatic sample(logic [47:0] s, bit raw);
        logic [47:0] e;
        e = ref_cor(s, ofs_xyz, raw);
        @(negedge clk); smp_valid = 1'b1; smp_xyz = s;
        @(negedge clk); smp_valid = 1'b0;
        chk(cor_valid == 1'b1, raw ? "R9 valid" : "R8 valid", cor_valid, 1);
        chk(cor_xyz == e, raw ? "R9 data" : "R8 data", cor_xyz, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n, k, p, f;
        bit sb;
        logic [7:0] b;
        void'($urandom(32'd1234));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 0);
        chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
        chk(sysmode == 2'b00 && !acq && !srst && !trig_busy, "R1 outs",
            {sysmode, acq, srst, trig_busy}, 0);

        // R3 standby stays quiet
        count_acq(300, k);
        chk(k == 0, "R3 standby acq", k, 0);

        // R2 continuous at top rate, R7 corrected mode code
        wr_ctrl(8'h01);
        chk(sysmode == 2'b10, "R7 corrected", sysmode, 2);
        wait_acq(200, n, sb);
        chk(n == per_cyc(0, 0) + 1, "R2 first", n, per_cyc(0, 0) + 1);
        wait_acq(200, n, sb);
        chk(n == per_cyc(0, 0), "R2 interval", n, per_cyc(0, 0));

        // R6 locked fields while running
        wr_ctrl(8'hFD);
        chk(ctrl_rdata == 8'h01, "R6 locked", ctrl_rdata, 8'h01);
        wait_acq(200, n, sb);
        chk(n == per_cyc(0, 0) - 2, "R6 rate kept", n, per_cyc(0, 0) - 2);

        // R2 random rate and oversampling
        for (int i = 0; i < 5; i++) begin
            int dr, os;
            dr = $urandom % 3;
            os = $urandom % 3;
            b = {dr[2:0], os[1:0], 1'($urandom % 2), 1'b0, 1'b1};
            p = per_cyc(dr, os);
            wr_ctrl(8'h00);
            wr_ctrl(b);
            chk(ctrl_rdata == b, "R2 cfg accepted", ctrl_rdata, b);
            wait_acq(4 * p, n, sb);
            chk(n == p + 1, "R2 random first", n, p + 1);
            wait_acq(4 * p, n, sb);
            chk(n == p, "R2 random interval", n, p);
        end

        // R4 one-shot from standby
        wr_ctrl(8'h00);
        wr_ctrl(8'h22);
        p = per_cyc(1, 0);
        chk(trig_busy == 1'b1, "R4 busy", trig_busy, 1);
        chk(sysmode == 2'b10, "R7 active trig", sysmode, 2);
        wait_acq(4 * p, n, sb);
        chk(n == p + 1, "R4 one-shot time", n, p + 1);
        chk(ctrl_rdata == 8'h20 && !trig_busy, "R4 back to standby",
            {ctrl_rdata, trig_busy}, {8'h20, 1'b0});
        chk(sysmode == 2'b00, "R4 mode", sysmode, 0);
        count_acq(3 * p, k);
        chk(k == 0, "R4 single shot", k, 0);

        // R5 trigger during continuous
        wr_ctrl(8'h49);
        p = per_cyc(2, 1);
        f = DIV * 16 * 2;
        wait_acq(4 * p, n, sb);
        chk(n == p + 1, "R5 setup", n, p + 1);
        ctrl_we = 1'b1;
        ctrl_wdata = 8'h4B;
        n = 0;
        while (n < 4 * p) begin
            @(negedge clk);
            ctrl_we = 1'b0;
            n++;
            if (acq) break;
        end
        chk(n == f, "R5 fast interval", n, f);
        chk(ctrl_rdata == 8'h49, "R5 trigger cleared", ctrl_rdata, 8'h49);
        wait_acq(4 * p, n, sb);
        chk(n == p, "R5 rate restored", n, p);

        // R10 auto reset leads acquire
        wr_cfg(8'h80);
        chk(cfg_rdata == 8'h00, "R10 reads zero", cfg_rdata, 0);
        wait_acq(4 * p, n, sb);
        chk(sb == 1'b1, "R10 srst before acq", sb, 1);
        wr_cfg(8'h00);
        wait_acq(4 * p, n, sb);
        chk(sb == 1'b0, "R10 off", sb, 0);

        // R7 raw mode code
        wr_cfg(8'h20);
        chk(sysmode == 2'b01, "R7 raw", sysmode, 1);
        wr_ctrl(8'h00);
        chk(sysmode == 2'b00, "R7 standby", sysmode, 0);

        // R11 manual reset
        wr_cfg(8'h10);
        chk(srst == 1'b1 && cfg_rdata == 8'h10, "R11 start", {srst, cfg_rdata}, {1'b1, 8'h10});
        for (int i = 1; i < RST_CYC; i++) begin
            @(negedge clk);
            chk(cfg_rdata[4] == 1'b1 && !srst, "R11 busy", {cfg_rdata[4], srst}, 2'b10);
        end
        @(negedge clk);
        chk(cfg_rdata == 8'h00, "R11 self clear", cfg_rdata, 0);

        // R8 offset add, directed wrap and even forcing
        ofs_xyz = {16'h7FFE, 16'hFFFF, 16'h0003};
        sample({16'h7FFF, 16'h0005, 16'h0010}, 1'b0);
        chk(cor_xyz == {16'hFFFD, 16'h0003, 16'h0012}, "R8 directed", cor_xyz,
            {16'hFFFD, 16'h0003, 16'h0012});
        @(negedge clk);
        chk(cor_valid == 1'b0, "R8 strobe drop", cor_valid, 0);
        for (int i = 0; i < 6; i++) begin
            ofs_xyz = {$urandom, $urandom};
            sample({$urandom, $urandom}, 1'b0);
        end

        // R9 raw pass-through
        wr_cfg(8'h20);
        for (int i = 0; i < 4; i++) begin
            ofs_xyz = {$urandom, $urandom};
            sample({$urandom, $urandom}, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule